// File: doc/BRIEF.md
# Autoincrementing Font RAM Loader

This block holds a small user-definable character set for a dot-matrix display. Every character is five consecutive 7-bit columns. All writes reach it through one command address. There, a byte with its top bit set is a pointer load, and a byte with its top bit clear is one column of pixel data. The column is stored at the current pointer, and the pointer then steps forward by one. A host can therefore load a whole glyph with one pointer write followed by five data writes.

The display scanner reads any stored column through an asynchronous read port. That port takes a flat column index: character n, column c sits at index 5·n + c. The block sits behind the serial transport. Its write side is a valid/ready stream that never applies back-pressure, since `wr_ready` is held high. A beat is accepted on every rising clock edge where `wr_valid` is high. The host may present a new beat on every cycle.

Top module: `font_ram_loader`

## Requirements
- R1: After reset the pointer is 0x80 and every one of the 80 columns reads as zero.
- R2: `wr_ready` is always high, and a beat is taken exactly on a clock edge where `wr_valid` is high. When `wr_valid` is low, nothing changes.
- R3: A beat whose `wr_addr` is not 0x05 changes neither the pointer nor any column.
- R4: A beat to 0x05 with `wr_data[7]` = 1 loads the pointer with the full 8-bit byte and stores nothing.
- R5: A beat to 0x05 with `wr_data[7]` = 0 stores `wr_data[6:0]` at pointer address p, which is column index p − 0x80. It then increments the pointer by one.
- R6: When the pointer lies in 0xD0..0xFF, a data beat stores nothing, but the pointer still increments.
- R7: A data beat taken while the pointer is 0xFF moves the pointer to 0x80, so the top bit always stays set.
- R8: `rd_data` follows `rd_col` combinationally. An index of 80 or above reads as zero.
- R9: The column of character n and column c (0..4) has pointer address 0x80 + 5·n + c. Loading 0x8A and writing five columns fills indices 10 through 14, in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write beat accepted (constant high) |
| wr_addr | input | 8 | Command address of the beat |
| wr_data | input | 8 | Pointer value (bit 7 = 1) or column data (bit 7 = 0) |
| rd_col | input | 7 | Flat column index for readback |
| rd_data | output | 7 | Stored column at `rd_col` |

## Verification
The assertions assume that `wr_valid`, `wr_addr` and `wr_data` are known and settled at every rising edge after reset. They also assume that the pointer checks see each beat in isolation, with no other source of pointer change. The bench drives every input on the falling edge, and it keeps `wr_valid` low except for the single cycle of each intended beat. It changes `rd_col` only while no beat is in flight, so each readback reflects settled state.

// File: rtl/font_ldr_pkg.sv
package font_ldr_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PTR  = 2'd1,
    OP_COL  = 2'd2
  } font_op_e;
endpackage

// File: rtl/font_cmd_decode.sv
module font_cmd_decode
  import font_ldr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] CMD = 8'h05
) (
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output font_op_e      op
);
  always_comb begin
    if (!valid || addr != CMD) op = OP_IDLE;
    else if (data[DW-1])       op = OP_PTR;
    else                       op = OP_COL;
  end
endmodule

// File: rtl/font_ptr_ctr.sv
module font_ptr_ctr
  import font_ldr_pkg::*;
#(
  parameter int PW = 8,
  parameter logic [PW-1:0] BASE = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  font_op_e      op,
  input  logic [PW-1:0] load_val,
  output logic [PW-1:0] ptr_q
);
  logic [PW-1:0] step;

  always_comb begin
    if (ptr_q == '1) step = BASE;
    else             step = ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= BASE;
    else begin
      case (op)
        OP_PTR:  ptr_q <= load_val;
        OP_COL:  ptr_q <= step;
        default: ptr_q <= ptr_q;
      endcase
    end
  end
endmodule

// File: rtl/font_col_ram.sv
module font_col_ram #(
  parameter int DEPTH = 80,
  parameter int CW    = 7,
  parameter int PW    = 8,
  parameter int IW    = 7,
  parameter logic [PW-1:0] BASE = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] ptr,
  input  logic [CW-1:0] wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [CW-1:0] rd_data
);
  localparam int LIMIT = int'(BASE) + DEPTH;

  logic [CW-1:0] mem [DEPTH];
  logic [PW-1:0] offs;
  logic          in_range;
  logic [DEPTH-1:0] row_we;

  assign offs     = ptr - BASE;
  assign in_range = (int'(ptr) >= int'(BASE)) && (int'(ptr) < LIMIT);

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    assign row_we[i] = wr_en && in_range && (offs == PW'(i));
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (!rst_n)         mem[k] <= '0;
      else if (row_we[k]) mem[k] <= wdata;
    end
  end

  always_comb begin
    if (int'(rd_idx) < DEPTH) rd_data = mem[rd_idx];
    else                      rd_data = '0;
  end
endmodule

// File: rtl/font_ram_loader.sv
module font_ram_loader
  import font_ldr_pkg::*;
#(
  parameter int NUM_CHARS = 16,
  parameter int COLS_PER_CHAR = 5,
  parameter int COL_W = 7,
  parameter int AW = 8,
  parameter logic [AW-1:0] FONT_CMD = 8'h05,
  parameter logic [AW-1:0] FONT_BASE = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] wr_data,
  input  logic [6:0]    rd_col,
  output logic [COL_W-1:0] rd_data
);
  localparam int DEPTH = NUM_CHARS * COLS_PER_CHAR;

  font_op_e       op;
  logic [AW-1:0]  ptr_q;

  assign wr_ready = 1'b1;

  font_cmd_decode #(.AW(AW), .DW(AW), .CMD(FONT_CMD)) u_dec (
    .valid(wr_valid), .addr(wr_addr), .data(wr_data), .op(op)
  );

  font_ptr_ctr #(.PW(AW), .BASE(FONT_BASE)) u_ptr (
    .clk(clk), .rst_n(rst_n), .op(op), .load_val(wr_data), .ptr_q(ptr_q)
  );

  font_col_ram #(.DEPTH(DEPTH), .CW(COL_W), .PW(AW), .IW(7), .BASE(FONT_BASE)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(op == OP_COL), .ptr(ptr_q),
    .wdata(wr_data[COL_W-1:0]), .rd_idx(rd_col), .rd_data(rd_data)
  );
endmodule

// File: rtl/font_ram_loader_chk.sv
module font_ram_loader_chk #(
  parameter logic [7:0] CMD  = 8'h05,
  parameter logic [7:0] BASE = 8'h80
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] ptr
);
  logic hit;
  assign hit = wr_valid && (wr_addr == CMD);

  a_r1_ptr_msb: assert property (@(posedge clk) disable iff (!rst_n) ptr[7]);

  a_r4_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    hit && wr_data[7] |=> ptr == $past(wr_data));

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !wr_data[7] && ptr != 8'hFF |=> ptr == $past(ptr) + 8'd1);

  a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !wr_data[7] && ptr == 8'hFF |=> ptr == BASE);

  a_r3_foreign_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr != CMD |=> $stable(ptr));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(ptr));
endmodule

bind font_ram_loader font_ram_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
  .wr_addr(wr_addr), .wr_data(wr_data), .ptr(ptr_q)
);

// File: tb/font_ram_loader_bench.sv
`timescale 1ns/10ps
module font_ram_loader_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [6:0] rd_col = 7'd0;
  logic [6:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [6:0] exp_mem [80];
  logic [7:0] exp_ptr;

  always #2.5 clk = ~clk;

  font_ram_loader u_font_ram_loader (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_col(rd_col), .rd_data(rd_data)
  );

  // reference model built from the requirements
  task automatic model_beat(input logic [7:0] a, input logic [7:0] d);
    if (a != 8'h05) return;
    if (d[7]) exp_ptr = d;
    else begin
      if (exp_ptr >= 8'h80 && exp_ptr < 8'hD0) exp_mem[exp_ptr - 8'h80] = d[6:0];
      exp_ptr = (exp_ptr == 8'hFF) ? 8'h80 : exp_ptr + 8'd1;
    end
  endtask

  task automatic beat(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    model_beat(a, d);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    int bad = 0;
    n_run++;
    for (int i = 0; i < 128; i++) begin
      logic [6:0] e;
      rd_col = 7'(i);
      #10ps;
      e = (i < 80) ? exp_mem[i] : 7'd0;
      if (rd_data !== e) begin
        bad++;
        $display("FAIL %s: index %0d actual %h expected %h", req, i, rd_data, e);
      end
    end
    if (bad != 0) n_fail++;
  endtask

  task automatic t_reset;
    chk_all("R1 reset columns zero");
    chk("R2 ready high", {7'd0, wr_ready}, 8'd1);
  endtask

  task automatic t_first_write; // R1 pointer 0x80, R5 store and step
    beat(8'h05, 8'h15);
    beat(8'h05, 8'h2A);
    rd_col = 7'd0; #10ps; chk("R1 first write at index 0", {1'b0, rd_data}, 8'h15);
    rd_col = 7'd1; #10ps; chk("R5 autoincrement", {1'b0, rd_data}, 8'h2A);
    chk_all("R5 whole ram");
  endtask

  task automatic t_glyph; // R4 R9 load 0x8A, five columns
    beat(8'h05, 8'h8A);
    beat(8'h05, 8'h42); beat(8'h05, 8'h61); beat(8'h05, 8'h51);
    beat(8'h05, 8'h49); beat(8'h05, 8'h46);
    rd_col = 7'd10; #10ps; chk("R9 char2 col0", {1'b0, rd_data}, 8'h42);
    rd_col = 7'd14; #10ps; chk("R9 char2 col4", {1'b0, rd_data}, 8'h46);
    chk_all("R4 pointer load stores nothing");
  endtask

  task automatic t_foreign; // R3
    beat(8'h8A, 8'h00);
    beat(8'h04, 8'h7F);
    beat(8'h06, 8'hC0);
    beat(8'h05, 8'h33); // lands at 0x8F, index 15, if R3 held
    rd_col = 7'd15; #10ps; chk("R3 pointer untouched", {1'b0, rd_data}, 8'h33);
    chk_all("R3 columns untouched");
  endtask

  task automatic t_idle; // R2
    @(negedge clk);
    wr_addr = 8'h05; wr_data = 8'h11; wr_valid = 1'b0;
    repeat (3) @(negedge clk);
    beat(8'h05, 8'h22); // next index 16
    rd_col = 7'd16; #10ps; chk("R2 no beat without valid", {1'b0, rd_data}, 8'h22);
    chk_all("R2 columns after idle");
  endtask

  task automatic t_edge_range; // R6
    beat(8'h05, 8'hCE);
    beat(8'h05, 8'h01); beat(8'h05, 8'h02);
    beat(8'h05, 8'h03); // at 0xD0, dropped
    rd_col = 7'd79; #10ps; chk("R6 last column", {1'b0, rd_data}, 8'h02);
    chk_all("R6 out of range dropped");
  endtask

  task automatic t_wrap; // R7 R6
    beat(8'h05, 8'hFE);
    beat(8'h05, 8'h55); // 0xFE dropped
    beat(8'h05, 8'h66); // 0xFF dropped, wraps
    beat(8'h05, 8'h77); // 0x80 stored
    rd_col = 7'd0; #10ps; chk("R7 wrap to 0x80", {1'b0, rd_data}, 8'h77);
    chk_all("R7 dropped beats before wrap");
  endtask

  task automatic t_oob_read; // R8
    rd_col = 7'd80;  #10ps; chk("R8 index 80 zero", {1'b0, rd_data}, 8'h00);
    rd_col = 7'd127; #10ps; chk("R8 index 127 zero", {1'b0, rd_data}, 8'h00);
    rd_col = 7'd11;  #10ps; chk("R8 async read", {1'b0, rd_data}, 8'h61);
  endtask

  initial begin
    for (int i = 0; i < 80; i++) exp_mem[i] = 7'd0;
    exp_ptr = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_write();
    t_glyph();
    t_foreign();
    t_idle();
    t_edge_range();
    t_wrap();
    t_oob_read();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #100us;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule